// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of every hardware thread in a multithreaded instruction-fetch stage. Each cycle it gathers per-thread block and unblock pulses from the four stages below fetch (decode, rename, execute, commit), squash requests from decode and from commit, a commit "still squashing" flag, and a global context-switch stall. From these it works out each thread's next status using a fixed priority. It also applies the cache-access and trap events that the fetch datapath reports for a thread.

The block keeps four sticky stall bits per thread. It captures the redirect PC and next PC that come with an accepted squash. It reports whether any thread's status was updated, and whether the fetch stage as a whole has work to do, with one-cycle activate and deactivate pulses on each change. Branch-predictor update is not part of this block.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Each thread has four sticky stall bits, reported on `stall_bits[4t+3:4t]` with bit 0 decode, bit 1 rename, bit 2 execute and bit 3 commit. A block pulse sets its bit and an unblock pulse clears it, both visible one cycle later. An unblock that arrives while its bit is clear, or in the same cycle as the matching block, raises `proto_err` for one cycle in the next cycle.
- R2: A commit squash wins over every other input, whatever the thread's status. In the next cycle the thread is Squashing and `redirect_pc`/`redirect_npc` hold the commit values.
- R3: With no commit squash, the commit still-squashing flag puts the thread in Squashing, unless the thread is trap-pending or quiesce-pending.
- R4: A decode squash loads the decode redirect values and sets Squashing only when the thread is not already Squashing. When the thread is already Squashing, the redirect registers keep their values and the lower rules apply.
- R5: When no squash rule fires and any updated stall bit or `ctx_switch_stall` is set, the thread becomes Blocked. This does not apply in wait-response, wait-retry, trap-pending or quiesce-pending.
- R6: When none of R2 to R5 applies, a thread in Blocked or Squashing returns to Running.
- R7: A thread in access-complete moves to Running when `sel_valid` names it and no higher rule applies.
- R8: When no higher rule applies, an event for the thread (`evt_valid`, `evt_tid`) acts by code as follows:
  - 1: Running to wait-response.
  - 2: Running to wait-retry.
  - 3: wait-retry to wait-response.
  - 4: wait-response to access-complete, or to Blocked if stalled.
  - 5: Running to trap-pending.
  - 6: Running to quiesce-pending.
  - 7: Running to Idle.

  An event in any other status is ignored.
- R9: A trap-pending or quiesce-pending thread leaves that status only through a commit squash, or through `wake_t0` for thread 0 (which goes to Running).
- R10: `stage_active` is registered high when any thread marked in `thread_active` has a next status of Running, Squashing or access-complete. `stage_activate` and `stage_deactivate` pulse for one cycle only on its rising and falling changes.
- R11: `status_changed` is high in the cycle after any thread's status was updated by R2 to R9.
- R12: Synchronous active-low reset clears every stall bit, puts every thread in Running, zeroes the redirect registers and clears all flags and pulses.
- R13: `thread_status[4t+3:4t]` uses these codes:

  | Status | Code |
  |---|---|
  | Running | 0 |
  | Idle | 1 |
  | Squashing | 2 |
  | Blocked | 3 |
  | wait-response | 4 |
  | wait-retry | 5 |
  | access-complete | 6 |
  | trap-pending | 7 |
  | quiesce-pending | 8 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_active | input | NUM_THREADS | Threads counted for stage activity |
| dec_block | input | NUM_THREADS | Decode block pulse per thread |
| dec_unblock | input | NUM_THREADS | Decode unblock pulse per thread |
| ren_block | input | NUM_THREADS | Rename block pulse per thread |
| ren_unblock | input | NUM_THREADS | Rename unblock pulse per thread |
| exe_block | input | NUM_THREADS | Execute block pulse per thread |
| exe_unblock | input | NUM_THREADS | Execute unblock pulse per thread |
| cmt_block | input | NUM_THREADS | Commit block pulse per thread |
| cmt_unblock | input | NUM_THREADS | Commit unblock pulse per thread |
| ctx_switch_stall | input | 1 | Global context-switch stall |
| cmt_squash | input | NUM_THREADS | Commit squash request per thread |
| cmt_pc | input | NUM_THREADS*PC_W | Commit redirect PC per thread |
| cmt_npc | input | NUM_THREADS*PC_W | Commit redirect next PC per thread |
| cmt_still_squash | input | NUM_THREADS | Commit still squashing per thread |
| dec_squash | input | NUM_THREADS | Decode squash request per thread |
| dec_pc | input | NUM_THREADS*PC_W | Decode redirect PC per thread |
| dec_npc | input | NUM_THREADS*PC_W | Decode redirect next PC per thread |
| evt_valid | input | 1 | Fetch datapath event valid |
| evt_tid | input | TID_W | Event thread |
| evt_code | input | 3 | Event code (R8) |
| sel_valid | input | 1 | A thread is selected for fetch |
| sel_tid | input | TID_W | Selected thread |
| wake_t0 | input | 1 | Wake thread 0 from trap/quiesce pending |
| thread_status | output | NUM_THREADS*4 | Status per thread (R13) |
| stall_bits | output | NUM_THREADS*4 | Sticky stall bits per thread |
| redirect_pc | output | NUM_THREADS*PC_W | Captured redirect PC |
| redirect_npc | output | NUM_THREADS*PC_W | Captured redirect next PC |
| proto_err | output | 1 | Illegal unblock seen last cycle |
| status_changed | output | 1 | A status was updated last cycle |
| stage_active | output | 1 | Fetch stage has work |
| stage_activate | output | 1 | Rising-edge pulse of stage_active |
| stage_deactivate | output | 1 | Falling-edge pulse of stage_active |

## Verification
The embedded properties assume that a stage never sends an unblock for a clear stall bit, or together with its own block. The `proto_err` path is the only place where that case is allowed. The random stimulus therefore draws an unblock only for a bit that the bench's own model holds set, and never in the same cycle as that bit's block. The one deliberate violation is a single directed cycle that checks `proto_err` and that no property covers. Events, selections, wakes and squashes are drawn freely, because the rules define how an event is ignored in a status that does not accept it.

// File: rtl/fsc_pkg.sv
// Shared types for the fetch status controller.
// Assumes: status codes and event codes are fixed and visible at the ports.
package fsc_pkg;

    typedef enum logic [3:0] {
        ST_RUN        = 4'd0,
        ST_IDLE       = 4'd1,
        ST_SQUASH     = 4'd2,
        ST_BLOCKED    = 4'd3,
        ST_WAIT_RESP  = 4'd4,
        ST_WAIT_RETRY = 4'd5,
        ST_ACC_DONE   = 4'd6,
        ST_TRAP       = 4'd7,
        ST_QUIESCE    = 4'd8
    } fstat_e;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_REQ_SENT   = 3'd1,
        EV_REQ_REJECT = 3'd2,
        EV_RETRY_SENT = 3'd3,
        EV_RESP       = 3'd4,
        EV_TRAP       = 3'd5,
        EV_QUIESCE    = 3'd6,
        EV_IDLE       = 3'd7
    } fevt_e;

    localparam int NUM_STAGES = 4;
    localparam int ST_W       = 4;

    // True for statuses that keep the fetch stage busy.
    function automatic logic is_live(fstat_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_ACC_DONE);
    endfunction

endpackage

// File: rtl/fsc_stall_bits.sv
// Sticky stall bits of one thread.
// Bit order: 0 decode, 1 rename, 2 execute, 3 commit.
// Assumes: block/unblock are single-cycle pulses. An illegal unblock is flagged
// (registered) and the bit still ends cleared.
module fsc_stall_bits
    import fsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] blk,
    input  logic [NUM_STAGES-1:0] unblk,
    output logic [NUM_STAGES-1:0] stall_q,
    output logic [NUM_STAGES-1:0] stall_nxt,
    output logic                  err_q
);

    // Next value of the bits: set by block, cleared by unblock.
    always_comb stall_nxt = (stall_q | blk) & ~unblk;

    // Hold the bits and the protocol error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= '0;
            err_q   <= 1'b0;
        end else begin
            stall_q <= stall_nxt;
            err_q   <= |(unblk & (~stall_q | blk));
        end
    end

    assert_block_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((blk != '0) && (unblk == '0)) |=> ((stall_q & $past(blk)) == $past(blk)));

    assert_unblock_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (unblk != '0) |=> ((stall_q & $past(unblk)) == '0));

endmodule

// File: rtl/fsc_thread_fsm.sv
// Status machine of one thread, with its captured redirect PC pair.
// Priority: commit squash, parked hold/wake, still-squash, decode squash,
// stall, recovery to Running, fetch selection, datapath event.
// Assumes: stall_any already folds in this cycle's block/unblock pulses.
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter bit IS_T0 = 1'b0
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_any,
    input  logic            cmt_sq,
    input  logic [PC_W-1:0] cmt_pc,
    input  logic [PC_W-1:0] cmt_npc,
    input  logic            still_sq,
    input  logic            dec_sq,
    input  logic [PC_W-1:0] dec_pc,
    input  logic [PC_W-1:0] dec_npc,
    input  logic            evt_hit,
    input  logic [2:0]      evt_code,
    input  logic            sel_hit,
    input  logic            wake,
    output fstat_e          st_q,
    output fstat_e          st_nxt,
    output logic [PC_W-1:0] pc_q,
    output logic [PC_W-1:0] npc_q,
    output logic            upd
);

    logic parked;
    logic ld_cmt;
    logic ld_dec;
    logic wake_ok;

    assign parked  = (st_q == ST_TRAP) || (st_q == ST_QUIESCE);
    assign wake_ok = wake && IS_T0;

    // Resolve the next status in fixed priority order.
    always_comb begin
        st_nxt = st_q;
        upd    = 1'b0;
        ld_cmt = 1'b0;
        ld_dec = 1'b0;
        if (cmt_sq) begin
            st_nxt = ST_SQUASH;
            upd    = 1'b1;
            ld_cmt = 1'b1;
        end else if (parked) begin
            if (wake_ok) begin
                st_nxt = ST_RUN;
                upd    = 1'b1;
            end
        end else if (still_sq) begin
            st_nxt = ST_SQUASH;
            upd    = 1'b1;
        end else if (dec_sq && (st_q != ST_SQUASH)) begin
            st_nxt = ST_SQUASH;
            upd    = 1'b1;
            ld_dec = 1'b1;
        end else if (stall_any && (st_q != ST_WAIT_RESP) && (st_q != ST_WAIT_RETRY)) begin
            st_nxt = ST_BLOCKED;
            upd    = 1'b1;
        end else if ((st_q == ST_BLOCKED) || (st_q == ST_SQUASH)) begin
            st_nxt = ST_RUN;
            upd    = 1'b1;
        end else if (sel_hit && (st_q == ST_ACC_DONE)) begin
            st_nxt = ST_RUN;
            upd    = 1'b1;
        end else if (evt_hit) begin
            unique case (fevt_e'(evt_code))
                EV_REQ_SENT: if (st_q == ST_RUN) begin
                    st_nxt = ST_WAIT_RESP;
                    upd    = 1'b1;
                end
                EV_REQ_REJECT: if (st_q == ST_RUN) begin
                    st_nxt = ST_WAIT_RETRY;
                    upd    = 1'b1;
                end
                EV_RETRY_SENT: if (st_q == ST_WAIT_RETRY) begin
                    st_nxt = ST_WAIT_RESP;
                    upd    = 1'b1;
                end
                EV_RESP: if (st_q == ST_WAIT_RESP) begin
                    st_nxt = stall_any ? ST_BLOCKED : ST_ACC_DONE;
                    upd    = 1'b1;
                end
                EV_TRAP: if (st_q == ST_RUN) begin
                    st_nxt = ST_TRAP;
                    upd    = 1'b1;
                end
                EV_QUIESCE: if (st_q == ST_RUN) begin
                    st_nxt = ST_QUIESCE;
                    upd    = 1'b1;
                end
                EV_IDLE: if (st_q == ST_RUN) begin
                    st_nxt = ST_IDLE;
                    upd    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Register the status and capture the redirect pair of an accepted squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            pc_q  <= '0;
            npc_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (ld_cmt) begin
                pc_q  <= cmt_pc;
                npc_q <= cmt_npc;
            end else if (ld_dec) begin
                pc_q  <= dec_pc;
                npc_q <= dec_npc;
            end
        end
    end

    assert_cmt_squash_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_sq |=> (st_q == ST_SQUASH) && (pc_q == $past(cmt_pc)) && (npc_q == $past(cmt_npc)));

    assert_dec_in_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SQUASH) && dec_sq && !cmt_sq) |=> ($stable(pc_q) && $stable(npc_q)));

    assert_wait_not_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_WAIT_RESP) && !cmt_sq && !still_sq && !dec_sq && !evt_hit) |=> (st_q == ST_WAIT_RESP));

    assert_parked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !cmt_sq && !wake_ok) |=> $stable(st_q));

endmodule

// File: rtl/fsc_activity.sv
// Stage activity tracker: registered busy flag with edge pulses.
// Assumes: st_nxt holds every thread's next status, 4 bits per thread.
module fsc_activity
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 4
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS-1:0]      active,
    input  logic [NUM_THREADS*ST_W-1:0] st_nxt,
    output logic                        busy_q,
    output logic                        act_q,
    output logic                        deact_q
);

    logic [NUM_THREADS-1:0] live;
    logic                   busy_nxt;

    // Mark threads whose next status keeps the stage busy.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            live[t] = active[t] && is_live(fstat_e'(st_nxt[t*ST_W +: ST_W]));
        end
        busy_nxt = |live;
    end

    // Register the busy flag and emit pulses only on its transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            act_q   <= 1'b0;
            deact_q <= 1'b0;
        end else begin
            busy_q  <= busy_nxt;
            act_q   <= busy_nxt && !busy_q;
            deact_q <= !busy_nxt && busy_q;
        end
    end

    assert_activate_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (busy_q && !$past(busy_q)));

    assert_deactivate_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deact_q |-> (!busy_q && $past(busy_q)));

endmodule

// File: rtl/fetch_status_ctrl.sv
// Per-thread fetch status controller, top level.
// One stall bank and one status machine per thread, plus a stage activity tracker.
// Assumes: all request inputs are single-cycle pulses sampled at the rising edge.
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THREADS-1:0]        thread_active,
    input  logic [NUM_THREADS-1:0]        dec_block,
    input  logic [NUM_THREADS-1:0]        dec_unblock,
    input  logic [NUM_THREADS-1:0]        ren_block,
    input  logic [NUM_THREADS-1:0]        ren_unblock,
    input  logic [NUM_THREADS-1:0]        exe_block,
    input  logic [NUM_THREADS-1:0]        exe_unblock,
    input  logic [NUM_THREADS-1:0]        cmt_block,
    input  logic [NUM_THREADS-1:0]        cmt_unblock,
    input  logic                          ctx_switch_stall,
    input  logic [NUM_THREADS-1:0]        cmt_squash,
    input  logic [NUM_THREADS*PC_W-1:0]   cmt_pc,
    input  logic [NUM_THREADS*PC_W-1:0]   cmt_npc,
    input  logic [NUM_THREADS-1:0]        cmt_still_squash,
    input  logic [NUM_THREADS-1:0]        dec_squash,
    input  logic [NUM_THREADS*PC_W-1:0]   dec_pc,
    input  logic [NUM_THREADS*PC_W-1:0]   dec_npc,
    input  logic                          evt_valid,
    input  logic [TID_W-1:0]              evt_tid,
    input  logic [2:0]                    evt_code,
    input  logic                          sel_valid,
    input  logic [TID_W-1:0]              sel_tid,
    input  logic                          wake_t0,
    output logic [NUM_THREADS*ST_W-1:0]   thread_status,
    output logic [NUM_THREADS*NUM_STAGES-1:0] stall_bits,
    output logic [NUM_THREADS*PC_W-1:0]   redirect_pc,
    output logic [NUM_THREADS*PC_W-1:0]   redirect_npc,
    output logic                          proto_err,
    output logic                          status_changed,
    output logic                          stage_active,
    output logic                          stage_activate,
    output logic                          stage_deactivate
);

    logic [NUM_THREADS-1:0]        upd_vec;
    logic [NUM_THREADS-1:0]        err_vec;
    logic [NUM_THREADS*ST_W-1:0]   st_nxt_flat;

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            logic [NUM_STAGES-1:0] blk;
            logic [NUM_STAGES-1:0] unblk;
            logic [NUM_STAGES-1:0] stall_q;
            logic [NUM_STAGES-1:0] stall_nxt;
            fstat_e                st_q;
            fstat_e                st_n;

            assign blk   = {cmt_block[t],   exe_block[t],   ren_block[t],   dec_block[t]};
            assign unblk = {cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]};

            fsc_stall_bits u_stall (
                .clk       (clk),
                .rst_n     (rst_n),
                .blk       (blk),
                .unblk     (unblk),
                .stall_q   (stall_q),
                .stall_nxt (stall_nxt),
                .err_q     (err_vec[t])
            );

            fsc_thread_fsm #(
                .PC_W  (PC_W),
                .IS_T0 (t == 0)
            ) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .stall_any ((|stall_nxt) || ctx_switch_stall),
                .cmt_sq    (cmt_squash[t]),
                .cmt_pc    (cmt_pc[t*PC_W +: PC_W]),
                .cmt_npc   (cmt_npc[t*PC_W +: PC_W]),
                .still_sq  (cmt_still_squash[t]),
                .dec_sq    (dec_squash[t]),
                .dec_pc    (dec_pc[t*PC_W +: PC_W]),
                .dec_npc   (dec_npc[t*PC_W +: PC_W]),
                .evt_hit   (evt_valid && (evt_tid == TID_W'(t))),
                .evt_code  (evt_code),
                .sel_hit   (sel_valid && (sel_tid == TID_W'(t))),
                .wake      (wake_t0),
                .st_q      (st_q),
                .st_nxt    (st_n),
                .pc_q      (redirect_pc[t*PC_W +: PC_W]),
                .npc_q     (redirect_npc[t*PC_W +: PC_W]),
                .upd       (upd_vec[t])
            );

            assign thread_status[t*ST_W +: ST_W]             = st_q;
            assign st_nxt_flat[t*ST_W +: ST_W]               = st_n;
            assign stall_bits[t*NUM_STAGES +: NUM_STAGES]    = stall_q;
        end
    endgenerate

    assign proto_err = |err_vec;

    // Record whether any thread's status was updated this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_changed <= 1'b0;
        else        status_changed <= |upd_vec;
    end

    fsc_activity #(
        .NUM_THREADS (NUM_THREADS)
    ) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (thread_active),
        .st_nxt  (st_nxt_flat),
        .busy_q  (stage_active),
        .act_q   (stage_activate),
        .deact_q (stage_deactivate)
    );

    assert_quiet_keeps_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vec == '0) |=> ($stable(thread_status) && !status_changed));

    assert_ctx_blocks_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_switch_stall && (cmt_squash == '0) && (cmt_still_squash == '0) && (dec_squash == '0)
         && (thread_status[ST_W-1:0] == ST_RUN)) |=> (thread_status[ST_W-1:0] == ST_BLOCKED));

endmodule

// File: tb/sim_fetch_status_ctrl.sv
// Bench: directed corners, then seeded random stimulus, checked against a model.
module sim_fetch_status_ctrl;

    localparam int NT = 4;
    localparam int PW = 32;
    localparam int TW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n;
    logic [NT-1:0] thread_active, dec_block, dec_unblock, ren_block, ren_unblock;
    logic [NT-1:0] exe_block, exe_unblock, cmt_block, cmt_unblock;
    logic ctx_switch_stall;
    logic [NT-1:0] cmt_squash, cmt_still_squash, dec_squash;
    logic [NT*PW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
    logic evt_valid;
    logic [TW-1:0] evt_tid;
    logic [2:0] evt_code;
    logic sel_valid;
    logic [TW-1:0] sel_tid;
    logic wake_t0;
    logic [NT*4-1:0] thread_status, stall_bits;
    logic [NT*PW-1:0] redirect_pc, redirect_npc;
    logic proto_err, status_changed, stage_active, stage_activate, stage_deactivate;

    fetch_status_ctrl #(.NUM_THREADS(NT), .PC_W(PW)) u0 (.*);

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state.
    logic [3:0]    m_st   [NT];
    logic [3:0]    m_stl  [NT];
    logic [PW-1:0] m_pc   [NT];
    logic [PW-1:0] m_npc  [NT];
    logic m_busy, m_act, m_deact, m_chg, m_err;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic live(logic [3:0] s);
        return (s == 4'd0) || (s == 4'd2) || (s == 4'd6);
    endfunction

    // Next status of one thread from the requirement rules.
    function automatic logic [4:0] next_st(int t, logic [3:0] s, logic stl);
        logic [3:0] n = s;
        logic u = 1'b0;
        logic parked = (s == 4'd7) || (s == 4'd8);
        if (cmt_squash[t]) begin n = 4'd2; u = 1; end
        else if (parked) begin
            if (wake_t0 && t == 0) begin n = 4'd0; u = 1; end
        end
        else if (cmt_still_squash[t]) begin n = 4'd2; u = 1; end
        else if (dec_squash[t] && s != 4'd2) begin n = 4'd2; u = 1; end
        else if (stl && s != 4'd4 && s != 4'd5) begin n = 4'd3; u = 1; end
        else if (s == 4'd3 || s == 4'd2) begin n = 4'd0; u = 1; end
        else if (sel_valid && sel_tid == TW'(t) && s == 4'd6) begin n = 4'd0; u = 1; end
        else if (evt_valid && evt_tid == TW'(t)) begin
            if (s == 4'd0 && evt_code == 3'd1) begin n = 4'd4; u = 1; end
            if (s == 4'd0 && evt_code == 3'd2) begin n = 4'd5; u = 1; end
            if (s == 4'd5 && evt_code == 3'd3) begin n = 4'd4; u = 1; end
            if (s == 4'd4 && evt_code == 3'd4) begin n = stl ? 4'd3 : 4'd6; u = 1; end
            if (s == 4'd0 && evt_code == 3'd5) begin n = 4'd7; u = 1; end
            if (s == 4'd0 && evt_code == 3'd6) begin n = 4'd8; u = 1; end
            if (s == 4'd0 && evt_code == 3'd7) begin n = 4'd1; u = 1; end
        end
        return {u, n};
    endfunction

    task automatic model_step();
        logic any_upd = 1'b0;
        logic err = 1'b0;
        logic busy = 1'b0;
        for (int t = 0; t < NT; t++) begin
            logic [3:0] blk = {cmt_block[t], exe_block[t], ren_block[t], dec_block[t]};
            logic [3:0] unb = {cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]};
            logic [3:0] sn = (m_stl[t] | blk) & ~unb;
            logic [4:0] r;
            err = err | (|(unb & (~m_stl[t] | blk)));
            r = next_st(t, m_st[t], (|sn) || ctx_switch_stall);
            any_upd = any_upd | r[4];
            if (cmt_squash[t]) begin
                m_pc[t] = cmt_pc[t*PW +: PW]; m_npc[t] = cmt_npc[t*PW +: PW];
            end else if (r[4] && r[3:0] == 4'd2 && dec_squash[t] && !cmt_still_squash[t]
                         && m_st[t] != 4'd2 && m_st[t] != 4'd7 && m_st[t] != 4'd8) begin
                m_pc[t] = dec_pc[t*PW +: PW]; m_npc[t] = dec_npc[t*PW +: PW];
            end
            m_st[t] = r[3:0];
            m_stl[t] = sn;
            busy = busy | (thread_active[t] && live(r[3:0]));
        end
        m_act = busy && !m_busy;
        m_deact = !busy && m_busy;
        m_busy = busy;
        m_chg = any_upd;
        m_err = err;
    endtask

    task automatic compare(string tag);
        for (int t = 0; t < NT; t++) begin
            check({tag, " status R13"}, 64'(thread_status[t*4 +: 4]), 64'(m_st[t]));
            check({tag, " stall bits R1"}, 64'(stall_bits[t*4 +: 4]), 64'(m_stl[t]));
            check({tag, " redirect pc R2"}, 64'(redirect_pc[t*PW +: PW]), 64'(m_pc[t]));
            check({tag, " redirect npc R4"}, 64'(redirect_npc[t*PW +: PW]), 64'(m_npc[t]));
        end
        check({tag, " changed R11"}, 64'(status_changed), 64'(m_chg));
        check({tag, " active R10"}, 64'(stage_active), 64'(m_busy));
        check({tag, " activate R10"}, 64'(stage_activate), 64'(m_act));
        check({tag, " deactivate R10"}, 64'(stage_deactivate), 64'(m_deact));
        check({tag, " proto err R1"}, 64'(proto_err), 64'(m_err));
    endtask

    task automatic clear_pulses();
        dec_block = '0; dec_unblock = '0; ren_block = '0; ren_unblock = '0;
        exe_block = '0; exe_unblock = '0; cmt_block = '0; cmt_unblock = '0;
        cmt_squash = '0; cmt_still_squash = '0; dec_squash = '0;
        evt_valid = 0; sel_valid = 0; wake_t0 = 0;
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        compare(tag);
        clear_pulses();
    endtask

    task automatic event_on(int t, int code);
        evt_valid = 1; evt_tid = TW'(t); evt_code = 3'(code);
    endtask

    task automatic rand_inputs();
        for (int t = 0; t < NT; t++) begin
            logic [3:0] b, u;
            for (int k = 0; k < 4; k++) begin
                b[k] = ($urandom % 16) == 0;
                u[k] = !b[k] && m_stl[t][k] && (($urandom % 4) == 0);
            end
            {cmt_block[t], exe_block[t], ren_block[t], dec_block[t]} = b;
            {cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]} = u;
            cmt_squash[t] = ($urandom % 40) == 0;
            cmt_still_squash[t] = ($urandom % 30) == 0;
            dec_squash[t] = ($urandom % 20) == 0;
        end
        cmt_pc = {$urandom, $urandom, $urandom, $urandom};
        cmt_npc = {$urandom, $urandom, $urandom, $urandom};
        dec_pc = {$urandom, $urandom, $urandom, $urandom};
        dec_npc = {$urandom, $urandom, $urandom, $urandom};
        ctx_switch_stall = ($urandom % 50) == 0;
        evt_valid = ($urandom % 2) == 0;
        evt_tid = TW'($urandom);
        evt_code = 3'($urandom % 7 + 1);
        sel_valid = ($urandom % 2) == 0;
        sel_tid = TW'($urandom);
        wake_t0 = ($urandom % 20) == 0;
        if (($urandom % 50) == 0) thread_active = NT'($urandom);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R12 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        clear_pulses();
        thread_active = '1;
        ctx_switch_stall = 0;
        cmt_pc = '0; cmt_npc = '0; dec_pc = '0; dec_npc = '0;
        evt_tid = '0; evt_code = '0; sel_tid = '0;
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_stl[t] = 0; m_pc[t] = 0; m_npc[t] = 0;
        end
        m_busy = 0; m_act = 0; m_deact = 0; m_chg = 0; m_err = 0;
        repeat (3) @(negedge clk);
        check("reset status R12", 64'(thread_status), 64'(0));
        check("reset stall R12", 64'(stall_bits), 64'(0));
        check("reset active R12", 64'({stage_active, stage_activate, status_changed, proto_err}), 64'(0));
        rst_n = 1;
        step("wakeup R10");
        check("first activate R10", 64'(stage_activate), 64'(1));

        dec_block[1] = 1; step("block R5");
        check("t1 blocked R5", 64'(thread_status[7:4]), 64'(3));
        check("t1 dec stall R1", 64'(stall_bits[7:4]), 64'(1));
        step("hold R5");
        dec_unblock[1] = 1; step("unblock R6");
        check("t1 running R6", 64'(thread_status[7:4]), 64'(0));

        cmt_squash[2] = 1; cmt_pc[95:64] = 32'h1000; cmt_npc[95:64] = 32'h1004;
        event_on(2, 1); step("commit squash R2");
        check("t2 squash pc R2", 64'(redirect_pc[95:64]), 64'h1000);
        check("t2 squashing R2", 64'(thread_status[11:8]), 64'(2));
        step("recover R6");

        cmt_still_squash[3] = 1; step("still squash R3");
        check("t3 squashing R3", 64'(thread_status[15:12]), 64'(2));
        dec_squash[3] = 1; dec_pc[127:96] = 32'hBEEF; dec_squash[0] = 1; dec_pc[31:0] = 32'h2000;
        step("dec squash R4");
        check("t3 pc kept R4", 64'(redirect_pc[127:96]), 64'(0));
        check("t3 running R4", 64'(thread_status[15:12]), 64'(0));
        check("t0 pc loaded R4", 64'(redirect_pc[31:0]), 64'h2000);
        step("recover t0 R6");

        event_on(0, 1); step("req sent R8");
        check("t0 wait resp R8", 64'(thread_status[3:0]), 64'(4));
        ctx_switch_stall = 1; step("stall in wait R5");
        check("t0 still waits R5", 64'(thread_status[3:0]), 64'(4));
        event_on(0, 4); step("resp stalled R8");
        check("t0 resp blocked R8", 64'(thread_status[3:0]), 64'(3));
        ctx_switch_stall = 0; step("unstall R6");
        event_on(0, 1); step("req again R8");
        event_on(0, 4); step("resp R8");
        check("t0 access complete R8", 64'(thread_status[3:0]), 64'(6));
        sel_valid = 1; sel_tid = 2'd1; step("other select R7");
        check("t0 not selected R7", 64'(thread_status[3:0]), 64'(6));
        sel_valid = 1; sel_tid = 2'd0; step("select R7");
        check("t0 running R7", 64'(thread_status[3:0]), 64'(0));
        event_on(1, 2); step("reject R8");
        event_on(1, 4); step("resp ignored R8");
        check("t1 wait retry R8", 64'(thread_status[7:4]), 64'(5));
        event_on(1, 3); step("retry R8");
        check("t1 wait resp R8", 64'(thread_status[7:4]), 64'(4));

        event_on(2, 5); step("trap R9");
        cmt_still_squash[2] = 1; wake_t0 = 1; step("trap held R9");
        check("t2 trap held R9", 64'(thread_status[11:8]), 64'(7));
        cmt_squash[2] = 1; step("trap exit R9");
        check("t2 trap left R9", 64'(thread_status[11:8]), 64'(2));
        event_on(0, 6); step("quiesce R9");
        wake_t0 = 1; step("wake R9");
        check("t0 woken R9", 64'(thread_status[3:0]), 64'(0));

        thread_active = '0; step("all off R10");
        check("deactivate R10", 64'(stage_deactivate), 64'(1));
        step("off hold R10");
        thread_active = '1; step("all on R10");

        ren_unblock[2] = 1; step("bad unblock R1");
        check("proto err raised R1", 64'(proto_err), 64'(1));
        step("err clears R1");

        for (int i = 0; i < 3000; i++) begin
            rand_inputs();
            step("random R3 R5 R8 R9");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule